// File: doc/BRIEF.md
# Flash Command Interface Controller

This block models the control side of a byte-wide flash memory. A host reaches it through an asynchronous-style bus with separate active-low chip select, write strobe and output strobe lines, a 17-bit address and an 8-bit data path. The data path is split into an input, an output and an output-drive flag. Each bus write is captured at the falling edge of the combined select-and-write condition. A command decoder turns unlock-prefixed write sequences into byte-program and sector-erase operations, which an internal sequencer then executes on an on-chip byte array.

While an operation is running, reads return a status byte instead of array data. Software polls this byte through a data-polling bit and a toggling bit. An erase runs on its own in two phases: every byte of the sector is first driven to 00h, and then the whole sector is set to FFh. Each sector has a protect input, and a low-supply input blocks all writes. The array size is a parameter: the default is 2048 bytes, and setting `ARRAY_AW` to 17 gives the full 128K-byte array. The busy time of each phase is set by cycle-count parameters.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the block is in read mode. No operation is pending, and `dataOe` is low while `ceN` is high.
- R2: `dataOe` is high exactly when `ceN` and `oeN` are both low.
- R3: Program sequence: AAh written to 05555h, 55h written to 02AAAh, A0h written to 05555h, then the data byte written to the target address. The stored byte becomes the old value ANDed with the data, and no other byte changes.
- R4: One program sequence writes one byte. A later plain write, without a new unlock prefix, leaves the array unchanged.
- R5: Erase sequence: AAh written to 05555h, 55h written to 02AAAh, 80h written to 05555h, AAh written to 05555h, 55h written to 02AAAh, then 30h written to any address in the sector. Every byte of that sector becomes FFh, and all other sectors are unchanged. The sector index is the top 3 bits of the array address.
- R6: While an operation is busy, a read returns status. Bit 7 is the complement of the programmed data's bit 7 during a program, and 0 during an erase. Bit 6 inverts on each new read. Bits 5:0 are 0.
- R7: When an operation completes, the block returns to read mode, reads return true array data, and a new command is accepted.
- R8: A program or erase whose final write addresses a sector with its `protect` bit set is dropped. The array is unchanged, and the block stays in read mode, so reads return array data.
- R9: A write made while `lowVcc` is high has no effect. It neither changes the array nor advances or aborts a command sequence.
- R10: A write that does not match the next step of a sequence (F0h included) returns the block to read mode. Writes made while an operation is busy are ignored.
- R11: A program is busy for `PROG_CYCLES` clock cycles. An erase is busy for 2 × (sector bytes) + `ERASE_CYCLES` cycles: a one-byte-per-cycle preprogram pass, the erase wait, and a one-byte-per-cycle fill pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Chip select, active low |
| weN | input | 1 | Write strobe, active low |
| oeN | input | 1 | Output strobe, active low |
| addr | input | ADDR_W | Byte address |
| dataIn | input | 8 | Write data |
| dataOut | output | 8 | Read data or status byte |
| dataOe | output | 1 | High when the block drives read data |
| lowVcc | input | 1 | Low-supply detect; blocks writes while high |
| protect | input | 2**SECTOR_BITS | Per-sector protect bits |

## Verification
Two functions can fall in the same cycle. The low-supply inhibit can coincide with the final data write of a program sequence, and a command write can land while an erase is still sweeping its sector. The bench provokes the first case by raising `lowVcc` for the data write alone and then issuing one plain write. It expects the inhibited byte to stay FFh and the plain write to be programmed, because the sequence must still be armed. It provokes the second case by issuing a complete program sequence during an erase, and it judges the result by reading that byte back as FFh once the erase has finished.

// File: rtl/flash_pkg.sv
package flash_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_UNL1,
    ST_UNL2,
    ST_PGM_ARM,
    ST_ERS_ARM,
    ST_ERS_UNL1,
    ST_ERS_UNL2,
    ST_PGM_BUSY,
    ST_PRE_BUSY,
    ST_ERS_BUSY,
    ST_FILL_BUSY
  } cmdState_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic latchOp;
    logic progWrite;
    logic preWrite;
    logic fillWrite;
    logic idxClr;
    logic idxInc;
    logic busy;
    logic eraseMode;
  } dpStrobes_t;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;
  localparam logic [7:0] OP_PROGRAM = 8'hA0;
  localparam logic [7:0] OP_ERASE   = 8'h80;
  localparam logic [7:0] OP_SECTOR  = 8'h30;

endpackage

// File: rtl/flash_ctrl.sv
module flash_ctrl
  import flash_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              lowVcc,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  input  logic              sectorProt,
  input  logic              idxLast,
  output dpStrobes_t        strobes,
  output cmdState_e         state
);

  localparam int CNT_MAX = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [ADDR_W-1:0] KEY_ADDR1 = ADDR_W'(17'h05555);
  localparam logic [ADDR_W-1:0] KEY_ADDR2 = ADDR_W'(17'h02AAA);

  cmdState_e        nextState;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             wrPrev;
  logic             wrNow;
  logic             wrStrobe;
  logic             isKey1, isKey2, isKey3Prog, isKey3Erase;

  assign wrNow    = !ceN && !weN;
  assign wrStrobe = wrNow && !wrPrev && !lowVcc;

  assign isKey1      = (addr == KEY_ADDR1) && (dataIn == KEY_FIRST);
  assign isKey2      = (addr == KEY_ADDR2) && (dataIn == KEY_SECOND);
  assign isKey3Prog  = (addr == KEY_ADDR1) && (dataIn == OP_PROGRAM);
  assign isKey3Erase = (addr == KEY_ADDR1) && (dataIn == OP_ERASE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      wrPrev <= 1'b0;
    end else begin
      state  <= nextState;
      cnt    <= cntNext;
      wrPrev <= wrNow;
    end
  end

  always_comb begin
    nextState = state;
    cntNext   = cnt;
    strobes   = '0;
    strobes.busy = (state == ST_PGM_BUSY) || (state == ST_PRE_BUSY) ||
                   (state == ST_ERS_BUSY) || (state == ST_FILL_BUSY);
    strobes.eraseMode = (state == ST_PRE_BUSY) || (state == ST_ERS_BUSY) ||
                        (state == ST_FILL_BUSY);
    case (state)
      ST_IDLE: begin
        if (wrStrobe && isKey1) nextState = ST_UNL1;
      end
      ST_UNL1: begin
        if (wrStrobe) nextState = isKey2 ? ST_UNL2 : ST_IDLE;
      end
      ST_UNL2: begin
        if (wrStrobe) begin
          if (isKey3Prog)       nextState = ST_PGM_ARM;
          else if (isKey3Erase) nextState = ST_ERS_ARM;
          else                  nextState = ST_IDLE;
        end
      end
      ST_PGM_ARM: begin
        if (wrStrobe) begin
          if (sectorProt) begin
            nextState = ST_IDLE;
          end else begin
            strobes.latchOp = 1'b1;
            cntNext         = CNT_W'(PROG_CYCLES - 1);
            nextState       = ST_PGM_BUSY;
          end
        end
      end
      ST_ERS_ARM: begin
        if (wrStrobe) nextState = isKey1 ? ST_ERS_UNL1 : ST_IDLE;
      end
      ST_ERS_UNL1: begin
        if (wrStrobe) nextState = isKey2 ? ST_ERS_UNL2 : ST_IDLE;
      end
      ST_ERS_UNL2: begin
        if (wrStrobe) begin
          if ((dataIn == OP_SECTOR) && !sectorProt) begin
            strobes.latchOp = 1'b1;
            strobes.idxClr  = 1'b1;
            nextState       = ST_PRE_BUSY;
          end else begin
            nextState = ST_IDLE;
          end
        end
      end
      ST_PGM_BUSY: begin
        if (cnt == '0) begin
          strobes.progWrite = 1'b1;
          nextState         = ST_IDLE;
        end else begin
          cntNext = cnt - CNT_W'(1);
        end
      end
      ST_PRE_BUSY: begin
        strobes.preWrite = 1'b1;
        strobes.idxInc   = 1'b1;
        if (idxLast) begin
          cntNext   = CNT_W'(ERASE_CYCLES - 1);
          nextState = ST_ERS_BUSY;
        end
      end
      ST_ERS_BUSY: begin
        if (cnt == '0) begin
          strobes.idxClr = 1'b1;
          nextState      = ST_FILL_BUSY;
        end else begin
          cntNext = cnt - CNT_W'(1);
        end
      end
      ST_FILL_BUSY: begin
        strobes.fillWrite = 1'b1;
        strobes.idxInc    = 1'b1;
        if (idxLast) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/flash_datapath.sv
module flash_datapath
  import flash_pkg::*;
#(
  parameter int ARRAY_AW    = 11,
  parameter int SECTOR_BITS = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        ceN,
  input  logic                        weN,
  input  logic                        oeN,
  input  logic [ARRAY_AW-1:0]         busAddr,
  input  logic [7:0]                  dataIn,
  input  logic [(1<<SECTOR_BITS)-1:0] protect,
  input  dpStrobes_t                  strobes,
  output logic                        sectorProt,
  output logic                        idxLast,
  output logic [7:0]                  dataOut,
  output logic                        dataOe
);

  localparam int ARRAY_BYTES = 1 << ARRAY_AW;
  localparam int SEC_AW      = ARRAY_AW - SECTOR_BITS;

  logic [7:0]             mem [ARRAY_BYTES];
  logic [ARRAY_AW-1:0]    opAddr;
  logic [7:0]             opData;
  logic [SEC_AW-1:0]      idx;
  logic [ARRAY_AW-1:0]    sweepAddr;
  logic [SECTOR_BITS-1:0] busSector;
  logic                   toggleBit;
  logic                   rdPrev;
  logic                   rdNow;
  logic [7:0]             statusByte;

  assign busSector  = busAddr[ARRAY_AW-1 -: SECTOR_BITS];
  assign sectorProt = protect[busSector];
  assign idxLast    = (idx == {SEC_AW{1'b1}});
  assign sweepAddr  = {opAddr[ARRAY_AW-1 -: SECTOR_BITS], idx};
  assign rdNow      = !ceN && !oeN && weN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opAddr    <= '0;
      opData    <= 8'hFF;
      idx       <= '0;
      toggleBit <= 1'b0;
      rdPrev    <= 1'b0;
    end else begin
      rdPrev <= rdNow;
      if (strobes.latchOp) begin
        opAddr <= busAddr;
        opData <= dataIn;
      end
      if (strobes.idxClr)      idx <= '0;
      else if (strobes.idxInc) idx <= idx + SEC_AW'(1);
      if (!strobes.busy)             toggleBit <= 1'b0;
      else if (rdNow && !rdPrev)     toggleBit <= ~toggleBit;
    end
  end

  // array: programming only clears bits, erase fills with ones
  always_ff @(posedge clk) begin
    if (strobes.progWrite)      mem[opAddr]    <= mem[opAddr] & opData;
    else if (strobes.preWrite)  mem[sweepAddr] <= 8'h00;
    else if (strobes.fillWrite) mem[sweepAddr] <= 8'hFF;
  end

  assign statusByte = {(strobes.eraseMode ? 1'b0 : ~opData[7]), toggleBit, 6'b0};
  assign dataOe     = !ceN && !oeN;

  always_comb begin
    if (!dataOe)           dataOut = 8'h00;
    else if (strobes.busy) dataOut = statusByte;
    else                   dataOut = mem[busAddr];
  end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int ARRAY_AW     = 11,
  parameter int SECTOR_BITS  = 3,
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        ceN,
  input  logic                        weN,
  input  logic                        oeN,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [7:0]                  dataIn,
  output logic [7:0]                  dataOut,
  output logic                        dataOe,
  input  logic                        lowVcc,
  input  logic [(1<<SECTOR_BITS)-1:0] protect
);

  dpStrobes_t strobes;
  cmdState_e  ctrlState;
  logic       sectorProt;
  logic       idxLast;

  flash_ctrl #(
    .ADDR_W      (ADDR_W),
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ceN       (ceN),
    .weN       (weN),
    .lowVcc    (lowVcc),
    .addr      (addr),
    .dataIn    (dataIn),
    .sectorProt(sectorProt),
    .idxLast   (idxLast),
    .strobes   (strobes),
    .state     (ctrlState)
  );

  flash_datapath #(
    .ARRAY_AW   (ARRAY_AW),
    .SECTOR_BITS(SECTOR_BITS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ceN       (ceN),
    .weN       (weN),
    .oeN       (oeN),
    .busAddr   (addr[ARRAY_AW-1:0]),
    .dataIn    (dataIn),
    .protect   (protect),
    .strobes   (strobes),
    .sectorProt(sectorProt),
    .idxLast   (idxLast),
    .dataOut   (dataOut),
    .dataOe    (dataOe)
  );

endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk
  import flash_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       ceN,
  input logic       oeN,
  input logic       lowVcc,
  input logic       dataOe,
  input logic [7:0] dataOut,
  input logic       busy,
  input logic       eraseMode,
  input logic       latchOp,
  input logic       progWrite,
  input logic       preWrite,
  input logic       fillWrite,
  input logic       sectorProt,
  input cmdState_e  state
);

  p_oe_drive_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !oeN) |-> dataOe);

  p_oe_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ceN || oeN) |-> !dataOe);

  p_single_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({progWrite, preWrite, fillWrite}));

  p_erase_poll_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && eraseMode) |-> !dataOut[7]);

  p_status_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && busy) |-> (dataOut[5:0] == 6'b0));

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (state == ST_IDLE));

  p_protect_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    latchOp |-> !sectorProt);

  p_lowvcc_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (lowVcc && !busy) |=> $stable(state));

endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .ceN       (ceN),
  .oeN       (oeN),
  .lowVcc    (lowVcc),
  .dataOe    (dataOe),
  .dataOut   (dataOut),
  .busy      (strobes.busy),
  .eraseMode (strobes.eraseMode),
  .latchOp   (strobes.latchOp),
  .progWrite (strobes.progWrite),
  .preWrite  (strobes.preWrite),
  .fillWrite (strobes.fillWrite),
  .sectorProt(sectorProt),
  .state     (ctrlState)
);

// File: tb/sim_flash_cmd_ctrl.sv
module sim_flash_cmd_ctrl;
  localparam int ADDR_W       = 17;
  localparam int ARRAY_AW     = 8;
  localparam int SECTOR_BITS  = 3;
  localparam int PROG_CYCLES  = 6;
  localparam int ERASE_CYCLES = 10;
  localparam int BYTES        = 1 << ARRAY_AW;
  localparam int SEC_BYTES    = BYTES >> SECTOR_BITS;
  localparam int NSEC         = 1 << SECTOR_BITS;
  localparam int ERASE_LEN    = 2 * SEC_BYTES + ERASE_CYCLES;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rstN, ceN, weN, oeN, lowVcc, dataOe;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        dataIn, dataOut;
  logic [NSEC-1:0]   protect;
  int                nRun = 0, nFail = 0;
  logic [7:0]        model [BYTES];

  flash_cmd_ctrl #(
    .ADDR_W(ADDR_W), .ARRAY_AW(ARRAY_AW), .SECTOR_BITS(SECTOR_BITS),
    .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) u0 (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN), .addr(addr),
    .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe), .lowVcc(lowVcc),
    .protect(protect)
  );

  function automatic logic [ADDR_W-1:0] fullAddr(input logic [ARRAY_AW-1:0] a);
    return {{(ADDR_W-ARRAY_AW){1'b0}}, a};
  endfunction

  function automatic logic [SECTOR_BITS-1:0] secOf(input logic [ARRAY_AW-1:0] a);
    return a[ARRAY_AW-1 -: SECTOR_BITS];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; dataIn = d; ceN = 1'b0; weN = 1'b0;
    @(negedge clk);
    weN = 1'b1; ceN = 1'b1;
  endtask

  task automatic busRead(input logic [ARRAY_AW-1:0] a, output logic [7:0] v, output logic oe);
    @(negedge clk);
    addr = fullAddr(a); ceN = 1'b0; oeN = 1'b0;
    @(posedge clk); #2;
    v = dataOut; oe = dataOe;
    @(negedge clk);
    ceN = 1'b1; oeN = 1'b1;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmdProgram(input logic [ARRAY_AW-1:0] a, input logic [7:0] d);
    busWrite(17'h05555, 8'hAA);
    busWrite(17'h02AAA, 8'h55);
    busWrite(17'h05555, 8'hA0);
    busWrite(fullAddr(a), d);
  endtask

  task automatic cmdErase(input logic [ARRAY_AW-1:0] a);
    busWrite(17'h05555, 8'hAA);
    busWrite(17'h02AAA, 8'h55);
    busWrite(17'h05555, 8'h80);
    busWrite(17'h05555, 8'hAA);
    busWrite(17'h02AAA, 8'h55);
    busWrite(fullAddr(a), 8'h30);
  endtask

  // called right after the final command write; returns busy length in cycles
  task automatic pollDone(input logic [ARRAY_AW-1:0] a, input logic exp7,
                          output int n, output logic [7:0] first);
    addr = fullAddr(a); ceN = 1'b0; oeN = 1'b0;
    n = 0; first = 8'h00;
    for (int k = 0; k < 2000; k++) begin
      @(posedge clk); #2;
      if (k == 0) first = dataOut;
      if (dataOut[7] === exp7) break;
      n++;
    end
    n = n + 1;
    @(negedge clk);
    ceN = 1'b1; oeN = 1'b1;
  endtask

  task automatic modelErase(input logic [SECTOR_BITS-1:0] s);
    for (int b = 0; b < SEC_BYTES; b++) model[{s, SEC_AWcast(b)}] = 8'hFF;
  endtask

  function automatic logic [ARRAY_AW-SECTOR_BITS-1:0] SEC_AWcast(input int b);
    return b[ARRAY_AW-SECTOR_BITS-1:0];
  endfunction

  task automatic expectByte(input string req, input logic [ARRAY_AW-1:0] a);
    logic [7:0] v;
    logic       oe;
    busRead(a, v, oe);
    check(req, {24'b0, v}, {24'b0, model[a]});
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [7:0] v, r1, r2, first;
    logic       oe;
    int         n;
    logic [ARRAY_AW-1:0] ra;
    logic [7:0]          rd;
    logic [3:0]          kind;

    void'($urandom(32'd20240611));
    rstN = 1'b0; ceN = 1'b1; weN = 1'b1; oeN = 1'b1; lowVcc = 1'b0;
    addr = '0; dataIn = '0; protect = '0;
    waitCycles(3);
    check("R1 no drive in reset", {31'b0, dataOe}, 32'd0);
    rstN = 1'b1;
    waitCycles(2);
    check("R1 idle after reset", {31'b0, dataOe}, 32'd0);

    // bring whole array to a known erased state (R5)
    for (int s = 0; s < NSEC; s++) begin
      cmdErase(ARRAY_AW'(s * SEC_BYTES + 3));
      waitCycles(ERASE_LEN + 2);
      modelErase(SECTOR_BITS'(s));
    end
    for (int b = 0; b < BYTES; b += 7) expectByte("R5 initial erase", ARRAY_AW'(b));

    // R2: output strobe gating
    busRead(8'h10, v, oe);
    check("R2 oe with both low", {31'b0, oe}, 32'd1);
    @(negedge clk); ceN = 1'b0; oeN = 1'b1;
    @(posedge clk); #2;
    check("R2 no oe when oeN high", {31'b0, dataOe}, 32'd0);
    @(negedge clk); ceN = 1'b1;

    // R3/R6/R11: program with status polling
    cmdProgram(8'h23, 8'h12);
    pollDone(8'h23, 1'b0, n, first);
    model[8'h23] = 8'h12;
    check("R11 program busy length", n, PROG_CYCLES);
    check("R6 program poll bit7", {31'b0, first[7]}, 32'd1);
    check("R6 status low bits", {26'b0, first[5:0]}, 32'd0);
    expectByte("R3 programmed byte", 8'h23);

    // R3/R7: second program ANDs bits
    cmdProgram(8'h23, 8'hF0);
    model[8'h23] = model[8'h23] & 8'hF0;
    waitCycles(PROG_CYCLES + 1);
    expectByte("R7 new command after done", 8'h23);
    expectByte("R3 neighbour untouched", 8'h22);

    // R4: plain write without prefix
    busWrite(fullAddr(8'h24), 8'h00);
    waitCycles(PROG_CYCLES + 1);
    expectByte("R4 plain write ignored", 8'h24);

    // R10: abort by F0 and by wrong step
    busWrite(17'h05555, 8'hAA);
    busWrite(17'h02AAA, 8'h55);
    busWrite(17'h05555, 8'hF0);
    busWrite(17'h05555, 8'hA0);
    busWrite(fullAddr(8'h30), 8'h00);
    waitCycles(PROG_CYCLES + 1);
    expectByte("R10 F0 aborts sequence", 8'h30);
    busWrite(17'h05555, 8'hAA);
    busWrite(17'h02AAA, 8'h77);
    busWrite(17'h02AAA, 8'h55);
    busWrite(17'h05555, 8'hA0);
    busWrite(fullAddr(8'h31), 8'h00);
    waitCycles(PROG_CYCLES + 1);
    expectByte("R10 wrong step aborts", 8'h31);

    // R5/R6/R10: erase of sector 7, toggle reads, writes while busy
    cmdProgram(8'hE5, 8'h00);
    waitCycles(PROG_CYCLES + 1);
    cmdErase(8'hE5);
    busRead(8'hE5, r1, oe);
    busRead(8'hE5, r2, oe);
    check("R6 erase poll bit7", {31'b0, r1[7]}, 32'd0);
    check("R6 toggle alternates", {31'b0, r1[6] ^ r2[6]}, 32'd1);
    cmdProgram(8'h05, 8'h00);
    waitCycles(ERASE_LEN + 2);
    modelErase(3'd7);
    expectByte("R10 write during busy ignored", 8'h05);
    expectByte("R5 sector erased", 8'hE5);
    expectByte("R5 sector erased", 8'hE0);
    expectByte("R5 other sector kept", 8'h23);

    // R11: erase duration
    cmdProgram(8'h45, 8'h00);
    waitCycles(PROG_CYCLES + 1);
    cmdErase(8'h40);
    pollDone(8'h45, 1'b1, n, first);
    modelErase(3'd2);
    check("R11 erase busy length", n, ERASE_LEN);
    expectByte("R5 erased after poll", 8'h45);

    // R8: protected sector
    cmdProgram(8'h66, 8'h5A);
    model[8'h66] = 8'h5A;
    waitCycles(PROG_CYCLES + 1);
    protect = 8'b0000_1000;
    cmdProgram(8'h66, 8'h00);
    busRead(8'h66, v, oe);
    check("R8 read mode kept", {24'b0, v}, 32'h5A);
    waitCycles(PROG_CYCLES + 1);
    expectByte("R8 protected program", 8'h66);
    cmdErase(8'h60);
    waitCycles(ERASE_LEN + 2);
    expectByte("R8 protected erase", 8'h66);
    protect = '0;

    // R9: low supply over whole sequence, then over the data write only
    lowVcc = 1'b1;
    cmdProgram(8'h88, 8'h00);
    lowVcc = 1'b0;
    waitCycles(PROG_CYCLES + 1);
    expectByte("R9 inhibited sequence", 8'h88);
    busWrite(17'h05555, 8'hAA);
    busWrite(17'h02AAA, 8'h55);
    busWrite(17'h05555, 8'hA0);
    lowVcc = 1'b1;
    busWrite(fullAddr(8'h88), 8'h00);
    lowVcc = 1'b0;
    busWrite(fullAddr(8'h89), 8'h0F);
    model[8'h89] = model[8'h89] & 8'h0F;
    waitCycles(PROG_CYCLES + 1);
    expectByte("R9 inhibited data write", 8'h88);
    expectByte("R9 sequence still armed", 8'h89);

    // constrained random mix
    for (int i = 0; i < 150; i++) begin
      kind = 4'($urandom_range(0, 9));
      ra   = ARRAY_AW'($urandom);
      rd   = 8'($urandom);
      if (kind <= 4'd6) begin
        cmdProgram(ra, rd);
        if (!protect[secOf(ra)]) model[ra] = model[ra] & rd;
        waitCycles(PROG_CYCLES + 1);
        expectByte("R3 random program", ra);
      end else if (kind == 4'd7) begin
        cmdErase(ra);
        if (!protect[secOf(ra)]) modelErase(secOf(ra));
        waitCycles(ERASE_LEN + 2);
        expectByte("R5 random erase", ra);
        expectByte("R5 random erase other", ra ^ ARRAY_AW'(SEC_BYTES));
      end else if (kind == 4'd8) begin
        lowVcc = 1'b1;
        cmdProgram(ra, 8'h00);
        lowVcc = 1'b0;
        waitCycles(PROG_CYCLES + 1);
        expectByte("R9 random inhibit", ra);
      end else begin
        protect = ($urandom_range(0, 2) == 0) ? NSEC'(1 << $urandom_range(0, NSEC - 1)) : '0;
      end
    end
    protect = '0;

    for (int b = 0; b < BYTES; b++) expectByte("R3 final array", ARRAY_AW'(b));

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule